// File: doc/BRIEF.md
# Bus Transaction Timeout Monitor

This block watches bus cycles started by on-chip masters and forces an error ending on any cycle whose target is too slow to answer. A transfer-start strobe from an internal master opens a timed window. The window closes when the cycle ends in one of three ways: an acknowledge, a bus error or a retry. If none of these comes within the programmed number of bus clocks, the block raises its own transfer-error pulse, which ends the cycle on the bus.

The limit is an 8-bit count of bus clocks, and a programmed value of zero stands for 256. The value on the limit input is captured when a cycle is accepted, so changing the input later does not move a timeout that is already running. While one cycle is being timed, further start strobes are ignored. Pulling the enable low drops any window in progress, and no error can occur until a new start is accepted with the enable high.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After a synchronous reset, `timeout_err_o` is 0 and no window is open. It stays 0 until a start is accepted.
- R2: A start strobe with `internal_i` = 0 opens no window. No error follows it, whatever the limit.
- R3: A start accepted at clock edge 0 with limit L (1..255), and with no termination after it, drives `timeout_err_o` high in the cycle after edge L.
- R4: An acknowledge sampled at any edge 1..L closes the window, and no error follows.
- R5: A bus error input sampled at any edge 1..L closes the window, and no error follows.
- R6: A retry sampled at any edge 1..L closes the window, and no error follows.
- R7: A limit input of 0 gives a window of 256 clocks.
- R8: The error pulse is exactly one clock wide. After it the monitor is idle, and a following start is timed from scratch.
- R9: A start strobe that arrives while a window is open is ignored. The timeout still falls at the time set by the first start.
- R10: While `enable_i` is low, no window opens. Pulling `enable_i` low at any edge up to and including edge L cancels the pending error.
- R11: The limit is captured at the accepted start. Later changes on `limit_i` do not change when the timeout falls.
- R12: If a termination is sampled at edge L, the same edge at which the limit is reached, the termination takes priority and no error is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_i | input | 1 | Monitor enable |
| start_i | input | 1 | Transfer-start strobe |
| internal_i | input | 1 | High when the current master is on-chip |
| ack_i | input | 1 | Transfer acknowledge |
| bus_err_i | input | 1 | Transfer error from the target |
| retry_i | input | 1 | Retry termination |
| limit_i | input | LIMIT_W | Response limit in bus clocks, 0 means 2^LIMIT_W |
| timeout_err_o | output | 1 | Registered one-clock transfer-error pulse |

## Verification
Two situations are the hardest to reach from the ports. The first is a termination that lands on exactly the edge where the limit runs out. The bench reaches it by sweeping the position of each termination kind across every edge from 1 to L+1, for each small limit. The second is the 256-clock window. The bench reaches it with a limit input of zero, one run with no termination and one run acknowledged on its final edge. Start strobes inside an open window, enable drops around edge L and limit changes in mid-window are added to the same per-cycle comparison.

// File: rtl/btm_pkg.sv
package btm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } btm_state_e;
endpackage

// File: rtl/btm_limit_reg.sv
module btm_limit_reg #(
  parameter int LIMIT_W = 8,
  localparam int CNT_W  = LIMIT_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic [CNT_W-1:0]   lim_eff_o
);
  localparam logic [CNT_W-1:0] FULL_SPAN = CNT_W'(1) << LIMIT_W;

  logic [LIMIT_W-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (rst)         lim_q <= '0;
    else if (load_i) lim_q <= limit_i;
  end

  // A zero setting means the full span
  always_comb begin
    if (lim_q == '0) lim_eff_o = FULL_SPAN;
    else             lim_eff_o = {1'b0, lim_q};
  end

  // R7: the effective limit is never zero and never above the full span
  assert_lim_range_R7: assert property (@(posedge clk) disable iff (rst)
    (lim_eff_o != '0) && (lim_eff_o <= FULL_SPAN));

  // R11: the captured value only changes on a load
  assert_lim_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(lim_eff_o));
endmodule

// File: rtl/btm_elapsed_ctr.sv
module btm_elapsed_ctr #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_eff_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign expire_o = run_i && (cnt_inc == lim_eff_i);

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (run_i && !expire_o)   cnt_q <= cnt_inc;
  end

  // R3: a running count stays below the limit
  assert_cnt_below_limit_R3: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q < lim_eff_i));

  // R8: every new window starts from zero
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/btm_cycle_ctrl.sv
module btm_cycle_ctrl
  import btm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic start_i,
  input  logic internal_i,
  input  logic term_i,
  input  logic expire_i,
  output logic accept_o,
  output logic run_o,
  output logic busy_o,
  output logic err_o
);
  btm_state_e state_q, state_d;
  logic       err_q;

  assign busy_o   = (state_q == ST_BUSY);
  assign accept_o = en_i && (state_q == ST_IDLE) && start_i && internal_i;
  assign run_o    = en_i && (state_q == ST_BUSY) && !term_i;
  assign err_o    = err_q;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o)            state_d = ST_BUSY;
        ST_BUSY: if (term_i || expire_i)  state_d = ST_IDLE;
        default:                          state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= expire_i;
    end
  end

  // R8: the error pulse lasts one clock
  assert_err_single_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);

  // R10: a low enable gives no error on the next clock
  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!err_q && !busy_o));

  // R4: a termination closes the window without an error
  assert_term_no_err_R4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && term_i) |=> (!err_q && !busy_o));

  // R2: a start from an external master does not open a window
  assert_ext_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && !internal_i) |=> !busy_o);

  // R9: an open window survives a further start strobe
  assert_restart_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && en_i && start_i && !term_i && !expire_i) |=> busy_o);
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable_i,
  input  logic               start_i,
  input  logic               internal_i,
  input  logic               ack_i,
  input  logic               bus_err_i,
  input  logic               retry_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               timeout_err_o
);
  localparam int CNT_W = LIMIT_W + 1;

  logic             term;
  logic             accept;
  logic             run;
  logic             busy;
  logic             expire;
  logic [CNT_W-1:0] lim_eff;

  // R4 R5 R6: any of the three endings closes the window
  assign term = ack_i || bus_err_i || retry_i;

  btm_limit_reg #(.LIMIT_W(LIMIT_W)) u_limit (
    .clk       (clk),
    .rst       (rst),
    .load_i    (accept),
    .limit_i   (limit_i),
    .lim_eff_o (lim_eff)
  );

  btm_elapsed_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (accept),
    .run_i     (run),
    .lim_eff_i (lim_eff),
    .expire_o  (expire)
  );

  btm_cycle_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en_i       (enable_i),
    .start_i    (start_i),
    .internal_i (internal_i),
    .term_i     (term),
    .expire_i   (expire),
    .accept_o   (accept),
    .run_o      (run),
    .busy_o     (busy),
    .err_o      (timeout_err_o)
  );

  // R3: a timeout leaves the monitor idle
  assert_err_then_idle_R3: assert property (@(posedge clk) disable iff (rst)
    timeout_err_o |-> !busy);
endmodule

// File: tb/test_bus_timeout_monitor.sv
module test_bus_timeout_monitor;
  logic       clk = 1'b0;
  logic       rst;
  logic       enable_i, start_i, internal_i, ack_i, bus_err_i, retry_i;
  logic [7:0] limit_i;
  logic       timeout_err_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bus_timeout_monitor #(.LIMIT_W(8)) i_bus_timeout_monitor (
    .clk           (clk),
    .rst           (rst),
    .enable_i      (enable_i),
    .start_i       (start_i),
    .internal_i    (internal_i),
    .ack_i         (ack_i),
    .bus_err_i     (bus_err_i),
    .retry_i       (retry_i),
    .limit_i       (limit_i),
    .timeout_err_o (timeout_err_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: timeout_err_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 ack, 2 bus error, 3 retry; at = sampling edge of termination
  task automatic scenario(input int lim, input int kind, input int at, input bit intl,
                          input int restart_at, input int en_low_from, input int lim_new,
                          input string tag);
    int  span;
    bit  fires;
    span  = (lim == 0) ? 256 : lim;
    fires = intl && !(kind != 0 && at >= 1 && at <= span)
                 && !(en_low_from >= 0 && en_low_from <= span);
    for (int i = 0; i <= span + 3; i++) begin
      @(negedge clk);
      if (i > 0)
        check($sformatf("%s lim=%0d kind=%0d at=%0d cyc=%0d", tag, lim, kind, at, i),
              timeout_err_o, fires && (i == span + 1));
      start_i    = (i == 0) || (i == restart_at);
      internal_i = intl;
      limit_i    = (i == 0) ? 8'(lim) : 8'(lim_new);
      ack_i      = (kind == 1) && (i == at);
      bus_err_i  = (kind == 2) && (i == at);
      retry_i    = (kind == 3) && (i == at);
      enable_i   = !(en_low_from >= 0 && i >= en_low_from);
    end
    @(negedge clk);
    start_i = 0; ack_i = 0; bus_err_i = 0; retry_i = 0; enable_i = 1; internal_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string tg;
    rst = 1; enable_i = 1; start_i = 0; internal_i = 0;
    ack_i = 0; bus_err_i = 0; retry_i = 0; limit_i = 8'd1;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: quiet after reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 reset state", timeout_err_o, 1'b0);
    end

    // R3 and R4 R5 R6 R12: sweep of limits and termination positions
    for (int l = 1; l <= 8; l++) begin
      scenario(l, 0, -1, 1'b1, -1, -1, l, "R3 no termination");
      for (int k = 1; k <= 3; k++) begin
        for (int a = 1; a <= l + 1; a++) begin
          if (a == l)      tg = "R12 termination on limit edge";
          else if (k == 1) tg = "R4 acknowledge";
          else if (k == 2) tg = "R5 bus error";
          else             tg = "R6 retry";
          scenario(l, k, a, 1'b1, -1, -1, l, tg);
        end
      end
    end

    // R2: external master
    for (int l = 1; l <= 4; l++) scenario(l, 0, -1, 1'b0, -1, -1, l, "R2 external master");

    // R7: zero means 256, plus top of range
    scenario(0, 0, -1, 1'b1, -1, -1, 0, "R7 zero limit");
    scenario(0, 1, 256, 1'b1, -1, -1, 0, "R7 zero limit ack at 256");
    scenario(255, 0, -1, 1'b1, -1, -1, 255, "R3 limit 255");

    // R8: back to back timeouts
    scenario(3, 0, -1, 1'b1, -1, -1, 3, "R8 first");
    scenario(3, 0, -1, 1'b1, -1, -1, 3, "R8 second");
    scenario(1, 0, -1, 1'b1, -1, -1, 1, "R8 short");

    // R9: starts inside an open window
    for (int r = 1; r <= 5; r++) scenario(5, 0, -1, 1'b1, r, -1, 5, "R9 restart ignored");
    scenario(1, 0, -1, 1'b1, 1, -1, 1, "R9 restart limit 1");

    // R10: enable
    scenario(4, 0, -1, 1'b1, -1, 0, 4, "R10 disabled at start");
    scenario(4, 0, -1, 1'b1, -1, 2, 4, "R10 disabled mid window");
    scenario(4, 0, -1, 1'b1, -1, 4, 4, "R10 disabled on limit edge");
    scenario(4, 0, -1, 1'b1, -1, 5, 4, "R10 disabled after timeout");

    // R11: limit captured at start
    scenario(3, 0, -1, 1'b1, -1, -1, 10, "R11 limit raised mid window");
    scenario(10, 0, -1, 1'b1, -1, -1, 2, "R11 limit lowered mid window");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule